// File: doc/BRIEF.md
# Shared-Exponent Complex Float Normalizer

This block turns a complex sample, given as two two's-complement fixed-point parts in the range [-1, 1), into a compact floating-point word. Each part is stored as a sign bit plus a fractional magnitude. Both parts use one unsigned exponent, which always means a negative power of two. The word therefore represents (re + j·im) × 2^(−exp).

A second, independent registered path turns such a word back into the fixed-point pair. A datapath can use the forward path to shrink samples before storing them between processing passes, and the reverse path to expand them again afterwards.

A magnitude field with its integer bit set (value exactly 1.0) is never produced for a normal sample. It is reserved to mark an input that could not be represented. Each path takes one clock cycle.

Top module: `cplx_sexp_norm`

## Requirements
- R1: The forward word is laid out, from MSB to LSB, as {re_sign, re_mag[MANT_W:0], im_sign, im_mag[MANT_W:0], exp[EXP_W-1:0]}. Each mag field holds the part's magnitude in units of 2^-MANT_W. For a normal sample, bit MANT_W of both mag fields is 0.
- R2: The exponent is the largest shift e ≤ 2^EXP_W−1 that keeps the larger part magnitude, times 2^e, below 1. Both parts are shifted by that same e. Unless exp equals 2^EXP_W−1 or both parts are zero, the larger mag field has bit MANT_W−1 set.
- R3: If either input part equals −1 (most negative code), fw_ovf_o is 1 and the word is the overflow code: both mag fields are 2^MANT_W, exp is 0, and the sign bits follow the inputs.
- R4: Bits lost below the mantissa are rounded to nearest, with ties rounded up.
- R5: If rounding the larger part reaches 1.0 and e > 0, exp becomes e−1 and both parts are re-rounded at that shift. If this happens at e = 0, any part that reached 1.0 saturates to 2^MANT_W−1.
- R6: An all-zero input gives an all-zero word.
- R7: Each sign bit is 1 exactly when the corresponding input part is negative, even when its magnitude rounds to 0.
- R8: fw_valid_o is fw_valid_i delayed by one cycle. Word and flag update one cycle after an accepted input. fw_ovf_o is 0 whenever fw_valid_o is 0.
- R9: The reverse path outputs sign × round_half_up(mag × 2^(IN_W−1−MANT_W) / 2^exp) as an IN_W-bit two's-complement value per part.
- R10: In the reverse path, a part whose mag bit MANT_W is set saturates: it goes to −2^(IN_W−1) if its sign is 1 and to 2^(IN_W−1)−1 otherwise. bw_ovf_o is then 1. A normal word never yields −2^(IN_W−1).
- R11: bw_valid_o is bw_valid_i delayed by one cycle. bw_ovf_o is 0 whenever bw_valid_o is 0.
- R12: A non-overflow sample that passes forward and then back differs from the input by at most 2^(IN_W−1−MANT_W−exp) input LSBs per part.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fw_valid_i | input | 1 | Forward input valid |
| fw_re_i | input | IN_W | Real part, two's complement fraction |
| fw_im_i | input | IN_W | Imaginary part, two's complement fraction |
| fw_valid_o | output | 1 | Forward result valid |
| fw_word_o | output | 2*(MANT_W+2)+EXP_W | Packed shared-exponent word |
| fw_ovf_o | output | 1 | Input could not be represented |
| bw_valid_i | input | 1 | Reverse input valid |
| bw_word_i | input | 2*(MANT_W+2)+EXP_W | Packed word to expand |
| bw_valid_o | output | 1 | Reverse result valid |
| bw_re_o | output | IN_W | Expanded real part |
| bw_im_o | output | IN_W | Expanded imaginary part |
| bw_ovf_o | output | 1 | A part carried the overflow magnitude |

## Verification
The hardest cases to reach from the ports are those where rounding the larger part carries to 1.0. To get there, every mantissa bit of the shifted value must be 1 and so must the first dropped bit. At e > 0 the exponent then steps back, and at e = 0 the result saturates. Uniform random values almost never hit these patterns. Directed vectors such as 0x3FFF and 0x7FFF force both outcomes. Random stimulus also draws a separate magnitude scale for each part, so that every exponent value is reached, including the clamp at the top exponent, and so that the smaller part often rounds down to a signed zero.

// File: rtl/cse_pkg.sv
package cse_pkg;
  localparam int IN_W_DEF   = 16;
  localparam int MANT_W_DEF = 12;
  localparam int EXP_W_DEF  = 3;

  function automatic int word_width(int mant_w, int exp_w);
    return 2 * (mant_w + 2) + exp_w;
  endfunction
endpackage

// File: rtl/cse_expsel.sv
module cse_expsel #(
  parameter int W     = 15,
  parameter int EXP_W = 3
) (
  input  logic [W-1:0]     mag_i,
  output logic [EXP_W-1:0] exp_o
);
  localparam logic [EXP_W-1:0] CAP = '1;

  logic [EXP_W-1:0] cnt;
  logic             hit;

  // leading zeros of the larger magnitude, clamped at the top exponent
  always_comb begin
    cnt = '0;
    hit = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!hit) begin
        if (mag_i[i])        hit = 1'b1;
        else if (cnt != CAP) cnt = cnt + 1'b1;
      end
    end
    exp_o = hit ? cnt : '0;
  end
endmodule

// File: rtl/cse_rnd.sv
module cse_rnd #(
  parameter int IN_W   = 16,
  parameter int MANT_W = 12,
  parameter int EXP_W  = 3
) (
  input  logic [IN_W-2:0]  mag_i,
  input  logic [EXP_W-1:0] sh_i,
  output logic [MANT_W:0]  mant_o
);
  localparam int DROP = IN_W - 1 - MANT_W;

  logic [IN_W-2:0] shifted;

  assign shifted = mag_i << sh_i;
  // round half up; carry into bit MANT_W signals 1.0
  assign mant_o  = {1'b0, shifted[IN_W-2 -: MANT_W]} + {{MANT_W{1'b0}}, shifted[DROP-1]};
endmodule

// File: rtl/cse_pack.sv
module cse_pack
  import cse_pkg::*;
#(
  parameter int IN_W   = IN_W_DEF,
  parameter int MANT_W = MANT_W_DEF,
  parameter int EXP_W  = EXP_W_DEF,
  localparam int PW    = word_width(MANT_W, EXP_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [IN_W-1:0] re_i,
  input  logic [IN_W-1:0] im_i,
  output logic            valid_o,
  output logic [PW-1:0]   word_o,
  output logic            ovf_o
);
  localparam logic [EXP_W-1:0] CAP      = '1;
  localparam logic [IN_W-1:0]  NEG_ONE  = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [MANT_W:0]  ONE_MANT = {1'b1, {MANT_W{1'b0}}};
  localparam logic [MANT_W:0]  MAX_MANT = {1'b0, {MANT_W{1'b1}}};

  logic [1:0][IN_W-1:0]   part;
  logic [1:0][IN_W-2:0]   mag;
  logic [1:0]             neg, oflow;
  logic [1:0][MANT_W:0]   mant_hi, mant_lo, mant_n;
  logic [IN_W-2:0]        big;
  logic [EXP_W-1:0]       e, e_m1, exp_n;
  logic                   carry, ovf_n;

  assign part = {re_i, im_i};  // index 1: real, 0: imaginary

  for (genvar p = 0; p < 2; p++) begin : g_part
    assign neg[p]   = part[p][IN_W-1];
    assign oflow[p] = (part[p] == NEG_ONE);
    assign mag[p]   = neg[p] ? (IN_W-1)'(-part[p]) : part[p][IN_W-2:0];

    cse_rnd #(.IN_W(IN_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) i_rnd_hi (
      .mag_i(mag[p]), .sh_i(e), .mant_o(mant_hi[p])
    );
    cse_rnd #(.IN_W(IN_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) i_rnd_lo (
      .mag_i(mag[p]), .sh_i(e_m1), .mant_o(mant_lo[p])
    );
  end

  assign big = (mag[1] > mag[0]) ? mag[1] : mag[0];

  cse_expsel #(.W(IN_W-1), .EXP_W(EXP_W)) i_expsel (
    .mag_i(big), .exp_o(e)
  );

  assign e_m1  = (e == '0) ? '0 : e - 1'b1;
  assign carry = mant_hi[1][MANT_W] | mant_hi[0][MANT_W];
  assign ovf_n = |oflow;

  always_comb begin
    exp_n  = e;
    mant_n = mant_hi;
    if (carry) begin
      if (e != '0) begin
        exp_n  = e_m1;
        mant_n = mant_lo;
      end else begin
        for (int p = 0; p < 2; p++)
          if (mant_n[p][MANT_W]) mant_n[p] = MAX_MANT;
      end
    end
    if (ovf_n) begin
      exp_n  = '0;
      mant_n = {ONE_MANT, ONE_MANT};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      ovf_o   <= valid_i & ovf_n;
      if (valid_i) word_o <= {neg[1], mant_n[1], neg[0], mant_n[0], exp_n};
    end
  end

  logic [MANT_W:0]  q_re, q_im;
  logic [EXP_W-1:0] q_exp;
  assign q_re  = word_o[EXP_W+MANT_W+2 +: MANT_W+1];
  assign q_im  = word_o[EXP_W +: MANT_W+1];
  assign q_exp = word_o[EXP_W-1:0];

  assert_valid_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !ovf_o));
  assert_below_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ovf_o) |-> (!q_re[MANT_W] && !q_im[MANT_W]));
  assert_ovf_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && ovf_o) |-> (q_exp == '0 && q_re == ONE_MANT && q_im == ONE_MANT));
  assert_normalized_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ovf_o && q_exp != CAP && (q_re != '0 || q_im != '0))
      |-> (q_re[MANT_W-1] || q_im[MANT_W-1]));
  assert_zero_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && re_i == '0 && im_i == '0) |=> (word_o == '0));
endmodule

// File: rtl/cse_unpack.sv
module cse_unpack
  import cse_pkg::*;
#(
  parameter int IN_W   = IN_W_DEF,
  parameter int MANT_W = MANT_W_DEF,
  parameter int EXP_W  = EXP_W_DEF,
  localparam int PW    = word_width(MANT_W, EXP_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PW-1:0]   word_i,
  output logic            valid_o,
  output logic [IN_W-1:0] re_o,
  output logic [IN_W-1:0] im_o,
  output logic            ovf_o
);
  localparam int DROP = IN_W - 1 - MANT_W;
  localparam logic [IN_W-1:0] MINV = {1'b1, {(IN_W-1){1'b0}}};
  localparam logic [IN_W-1:0] MAXV = {1'b0, {(IN_W-1){1'b1}}};

  logic [EXP_W-1:0]     e;
  logic [1:0][IN_W-1:0] val, res_q;
  logic [1:0]           sat;

  assign e = word_i[EXP_W-1:0];

  for (genvar p = 0; p < 2; p++) begin : g_part
    localparam int BASE = EXP_W + p * (MANT_W + 2);
    logic [MANT_W:0]  m;
    logic             s;
    logic [IN_W-1:0]  ext, half, mag_v;

    assign m      = word_i[BASE +: MANT_W+1];
    assign s      = word_i[BASE+MANT_W+1];
    assign sat[p] = m[MANT_W];
    assign ext    = {1'b0, m[MANT_W-1:0], {DROP{1'b0}}};
    assign half   = (e == '0) ? '0 : (IN_W'(1) << (e - 1'b1));
    assign mag_v  = (ext + half) >> e;
    assign val[p] = sat[p] ? (s ? MINV : MAXV) : (s ? -mag_v : mag_v);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      res_q   <= '0;
      ovf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      ovf_o   <= valid_i & (|sat);
      if (valid_i) res_q <= val;
    end
  end

  assign re_o = res_q[1];
  assign im_o = res_q[0];

  assert_valid_delay_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_valid_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !ovf_o));
  assert_no_minus_one_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !ovf_o) |-> (re_o != MINV && im_o != MINV));
endmodule

// File: rtl/cplx_sexp_norm.sv
module cplx_sexp_norm
  import cse_pkg::*;
#(
  parameter int IN_W   = IN_W_DEF,
  parameter int MANT_W = MANT_W_DEF,
  parameter int EXP_W  = EXP_W_DEF,
  localparam int PW    = word_width(MANT_W, EXP_W)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fw_valid_i,
  input  logic [IN_W-1:0] fw_re_i,
  input  logic [IN_W-1:0] fw_im_i,
  output logic            fw_valid_o,
  output logic [PW-1:0]   fw_word_o,
  output logic            fw_ovf_o,
  input  logic            bw_valid_i,
  input  logic [PW-1:0]   bw_word_i,
  output logic            bw_valid_o,
  output logic [IN_W-1:0] bw_re_o,
  output logic [IN_W-1:0] bw_im_o,
  output logic            bw_ovf_o
);
  cse_pack #(.IN_W(IN_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) i_pack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (fw_valid_i),
    .re_i    (fw_re_i),
    .im_i    (fw_im_i),
    .valid_o (fw_valid_o),
    .word_o  (fw_word_o),
    .ovf_o   (fw_ovf_o)
  );

  cse_unpack #(.IN_W(IN_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) i_unpack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (bw_valid_i),
    .word_i  (bw_word_i),
    .valid_o (bw_valid_o),
    .re_o    (bw_re_o),
    .im_o    (bw_im_o),
    .ovf_o   (bw_ovf_o)
  );
endmodule

// File: tb/test_cplx_sexp_norm.sv
module test_cplx_sexp_norm;
  localparam int IN_W   = 16;
  localparam int MANT_W = 12;
  localparam int EXP_W  = 3;
  localparam int PW     = 2 * (MANT_W + 2) + EXP_W;
  localparam int CAPE   = (1 << EXP_W) - 1;
  localparam longint FMAX = longint'(1) << (IN_W - 1);
  localparam longint DIV  = longint'(1) << (IN_W - 1 - MANT_W);
  localparam longint ONEM = longint'(1) << MANT_W;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fw_valid_i = 1'b0;
  logic [IN_W-1:0] fw_re_i = '0, fw_im_i = '0;
  logic fw_valid_o, fw_ovf_o;
  logic [PW-1:0] fw_word_o;
  logic bw_valid_i = 1'b0;
  logic [PW-1:0] bw_word_i = '0;
  logic bw_valid_o, bw_ovf_o;
  logic signed [IN_W-1:0] bw_re_o, bw_im_o;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2 clk_i = ~clk_i;

  cplx_sexp_norm #(.IN_W(IN_W), .MANT_W(MANT_W), .EXP_W(EXP_W)) i_cplx_sexp_norm (
    .clk_i, .rst_ni, .fw_valid_i, .fw_re_i, .fw_im_i, .fw_valid_o, .fw_word_o,
    .fw_ovf_o, .bw_valid_i, .bw_word_i, .bw_valid_o, .bw_re_o, .bw_im_o, .bw_ovf_o
  );

  function automatic longint f_exp(logic [PW-1:0] w);    return longint'(w[EXP_W-1:0]); endfunction
  function automatic longint f_re_mag(logic [PW-1:0] w); return longint'(w[EXP_W+MANT_W+2 +: MANT_W+1]); endfunction
  function automatic longint f_im_mag(logic [PW-1:0] w); return longint'(w[EXP_W +: MANT_W+1]); endfunction
  function automatic longint f_re_sgn(logic [PW-1:0] w); return longint'(w[PW-1]); endfunction
  function automatic longint f_im_sgn(logic [PW-1:0] w); return longint'(w[EXP_W+MANT_W+1]); endfunction

  function automatic longint rnd_q(longint a, int e);
    return ((a << e) + DIV / 2) / DIV;
  endfunction

  function automatic void model_pack(input longint re, input longint im,
                                     output logic [PW-1:0] w, output bit ov);
    longint ar, ai, m, mr, mi, sr, si;
    int e;
    sr = (re < 0) ? 1 : 0;
    si = (im < 0) ? 1 : 0;
    ov = (re == -FMAX) || (im == -FMAX);
    if (ov) begin
      w = PW'((sr << (PW-1)) | (ONEM << (EXP_W+MANT_W+2)) | (si << (EXP_W+MANT_W+1)) | (ONEM << EXP_W));
      return;
    end
    ar = (re < 0) ? -re : re;
    ai = (im < 0) ? -im : im;
    m  = (ar > ai) ? ar : ai;
    e  = 0;
    if (m != 0)
      while (e < CAPE && (m << (e + 1)) < FMAX) e++;
    mr = rnd_q(ar, e);
    mi = rnd_q(ai, e);
    if (mr == ONEM || mi == ONEM) begin
      if (e > 0) begin
        e--;
        mr = rnd_q(ar, e);
        mi = rnd_q(ai, e);
      end else begin
        if (mr == ONEM) mr = ONEM - 1;
        if (mi == ONEM) mi = ONEM - 1;
      end
    end
    w = PW'((sr << (PW-1)) | (mr << (EXP_W+MANT_W+2)) | (si << (EXP_W+MANT_W+1)) |
            (mi << EXP_W) | longint'(e));
  endfunction

  function automatic longint model_unpack(longint mag, longint sgn, longint e);
    longint v, h;
    if (mag >= ONEM) return sgn ? -FMAX : FMAX - 1;
    h = (e == 0) ? 0 : (longint'(1) << (e - 1));
    v = ((mag * DIV) + h) >> e;
    return sgn ? -v : v;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
    end
  endtask

  // drive one sample on both paths, the reverse path fed with the modelled word
  task automatic run_one(longint re, longint im);
    logic [PW-1:0] w;
    bit ov;
    longint br, bi, tol, dr, di;
    model_pack(re, im, w, ov);
    fw_valid_i = 1'b1;
    fw_re_i    = IN_W'(re);
    fw_im_i    = IN_W'(im);
    bw_valid_i = 1'b1;
    bw_word_i  = w;
    @(negedge clk_i);
    check(fw_valid_o && fw_word_o == w, "R1 R2 R4 R5 R7 forward word", longint'(fw_word_o), longint'(w));
    check(fw_ovf_o == ov, "R3 forward overflow flag", longint'(fw_ovf_o), longint'(ov));
    br = model_unpack(f_re_mag(w), f_re_sgn(w), f_exp(w));
    bi = model_unpack(f_im_mag(w), f_im_sgn(w), f_exp(w));
    check(bw_valid_o && longint'(bw_re_o) == br && longint'(bw_im_o) == bi,
          "R9 R10 reverse value", (longint'(bw_re_o) << 20) ^ longint'(bw_im_o), (br << 20) ^ bi);
    check(bw_ovf_o == ov, "R10 reverse overflow flag", longint'(bw_ovf_o), longint'(ov));
    if (!ov) begin
      tol = DIV >> f_exp(w);
      dr  = longint'(bw_re_o) - re;
      di  = longint'(bw_im_o) - im;
      if (dr < 0) dr = -dr;
      if (di < 0) di = -di;
      check(dr <= tol && di <= tol, "R12 round trip error", (dr > di) ? dr : di, tol);
    end
  endtask

  task automatic idle();
    fw_valid_i = 1'b0;
    bw_valid_i = 1'b0;
    @(negedge clk_i);
    check(!fw_valid_o && !fw_ovf_o, "R8 forward idle", longint'(fw_valid_o), 0);
    check(!bw_valid_o && !bw_ovf_o, "R11 reverse idle", longint'(bw_valid_o), 0);
  endtask

  function automatic longint rnd_part();
    int     s = $urandom_range(IN_W - 2, 0);
    longint v = longint'($urandom) & ((longint'(1) << (IN_W - 1 - s)) - 1);
    if ($urandom_range(1, 0) == 1) v = -v;
    return v;
  endfunction

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk_i);
    check(!fw_valid_o && fw_word_o == '0 && !bw_valid_o && bw_re_o == '0,
          "R8 R11 reset state", longint'(fw_word_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    run_one(0, 0);
    check(fw_word_o == '0 && !fw_ovf_o, "R6 zero input word", longint'(fw_word_o), 0);

    run_one(-FMAX, 5);
    check(fw_ovf_o && f_exp(fw_word_o) == 0 && f_re_mag(fw_word_o) == ONEM &&
          f_im_mag(fw_word_o) == ONEM, "R3 overflow code", longint'(fw_word_o), 0);
    check(bw_ovf_o && longint'(bw_re_o) == -FMAX && longint'(bw_im_o) == FMAX - 1,
          "R10 reverse saturation", longint'(bw_re_o), -FMAX);

    run_one(FMAX - 1, 0);
    check(f_exp(fw_word_o) == 0 && f_re_mag(fw_word_o) == ONEM - 1,
          "R5 saturation at exponent 0", f_re_mag(fw_word_o), ONEM - 1);

    run_one(16'h3FFF, 16'h1000);
    check(f_exp(fw_word_o) == 0 && f_re_mag(fw_word_o) == 2048 && f_im_mag(fw_word_o) == 512,
          "R5 carry steps exponent back", f_re_mag(fw_word_o), 2048);

    run_one(3, -1);
    check(f_exp(fw_word_o) == CAPE && f_re_mag(fw_word_o) == 48 && f_im_mag(fw_word_o) == 16,
          "R2 exponent clamp", f_exp(fw_word_o), CAPE);

    run_one(16'h4004, 0);
    check(f_re_mag(fw_word_o) == 2049, "R4 tie rounds up", f_re_mag(fw_word_o), 2049);
    run_one(16'h4003, 0);
    check(f_re_mag(fw_word_o) == 2048, "R4 below half rounds down", f_re_mag(fw_word_o), 2048);

    run_one(16'h4000, -1);
    check(f_im_sgn(fw_word_o) == 1 && f_im_mag(fw_word_o) == 0, "R7 negative zero sign",
          f_im_sgn(fw_word_o), 1);

    run_one(-200, 16'h0100);
    check(f_re_sgn(fw_word_o) == 1 && f_im_sgn(fw_word_o) == 0 && f_exp(fw_word_o) == 6,
          "R2 R7 mixed signs", f_exp(fw_word_o), 6);

    idle();

    for (int k = 0; k < 3000; k++) begin
      if (k % 9 == 8) idle();
      else            run_one(rnd_part(), rnd_part());
    end
    idle();

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule